// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Model with Write Guard

This block is a clocked behavioural model of an 8K x 8 electrically erasable memory with a parallel bus. It takes a 13-bit address, an 8-bit input data bus and three active-low strobes: chip select, output enable and write strobe. The read data comes back on an output bus with a separate drive-enable flag, which stands in for a tri-state pin. A byte write copies the data into the array and then holds the part busy for `WC_CYCLES` clocks, standing in for the internal programming time.

While the part is busy, a read returns a status word instead of array data. The top bit is the inverse of the top bit of the byte being programmed. The next bit flips on every read. The remaining bits are zero. Software polls one of these bits until the true data returns.

A command detector watches the write stream for fixed address/data sequences. One sequence turns write protection on and lets the byte written right after it through. A longer sequence turns write protection off. While protection is on, a plain write is dropped. Writes that match a step of a sequence are taken by the detector and are never programmed.

Top module: `eeprom_guard`

## Requirements
- R1: After reset the data bus is not driven and write protection is off.
- R2: A read cycle is a clock where chip select and output enable are low and the write strobe is high. The drive-enable flag is high only in such a cycle, and the output is zero whenever the flag is low.
- R3: With protection off, a plain byte write stores the byte. A later read of that address, made once the part is no longer busy, returns it.
- R4: A write cycle is a clock where chip select and the write strobe are low. An accepted write keeps the part busy for exactly `WC_CYCLES` clocks. A read in the clock right after the last busy clock returns the stored byte.
- R5: During a busy interval, bit 7 of every read is the inverse of bit 7 of the byte being programmed.
- R6: During a busy interval, bit 6 flips between consecutive reads and bits 5..0 read as zero. Once the interval ends, repeated reads return the same stored byte.
- R7: A write issued while the part is busy is ignored and does not extend the busy interval.
- R8: The writes 0xAA at 0x1555, 0x55 at 0x0AAA and 0xA0 at 0x1555 turn protection on. The next byte write after them is stored.
- R9: With protection on, a byte write that does not follow the sequence in R8 changes no data and starts no busy interval.
- R10: The six writes 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555 turn protection off.
- R11: A read, or a write that is not the expected next step, sends the detector back to idle. The mismatching write is then handled as a plain write.
- R12: A write that the detector takes as a sequence step stores nothing and starts no busy interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data |
| dq_out | output | 8 | Read data or busy status |
| dq_oe | output | 1 | High while the read data is driven |

## Verification
The bench stores a sweep of addresses and data patterns and reads every byte back. It then reads on every clock of a busy interval to check the exact end clock. A counter that is off by one would return the status word one clock too long, or the data one clock too early. The status bits are compared read by read, so a toggle bit that does not flip, or a stale inverted bit, shows up at once. The bench also drives broken sequences (a read in the middle, one wrong address, a stray third step) and lone writes under protection. It reads back the target bytes and the command addresses, so a detector that stores sequence bytes or accepts a write without the unlock leaves a byte that differs from the expected one.

// File: rtl/eeg_pkg.sv
package eeg_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE, SQ_GOT1, SQ_GOT2, SQ_DIS3, SQ_DIS4, SQ_DIS5, SQ_OPEN
   } seq_t;

   localparam logic [12:0] CMD_HI_ADDR = 13'h1555;
   localparam logic [12:0] CMD_LO_ADDR = 13'h0AAA;
   localparam logic [7:0]  KEY_FIRST   = 8'hAA;
   localparam logic [7:0]  KEY_SECOND  = 8'h55;
   localparam logic [7:0]  KEY_LOCK    = 8'hA0;
   localparam logic [7:0]  KEY_DIS_A   = 8'h80;
   localparam logic [7:0]  KEY_DIS_B   = 8'h20;
endpackage

// File: rtl/eeg_cmd_seq.sv
module eeg_cmd_seq
   import eeg_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_acc,
   input  logic              rd_acc,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              prot,
   output logic              consume,
   output logic              open_win
);
   seq_t st, st_nxt;
   logic do_arm, do_disarm;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                                input logic [12:0] ka, input logic [7:0] kd);
      return (a == ADDR_W'(ka)) && (d == DATA_W'(kd));
   endfunction

   always_comb begin
      st_nxt    = st;
      consume   = 1'b0;
      do_arm    = 1'b0;
      do_disarm = 1'b0;
      if (rd_acc) begin
         st_nxt = SQ_IDLE;
      end else if (wr_acc) begin
         st_nxt = SQ_IDLE;
         unique case (st)
            SQ_IDLE: if (hit(addr, din, CMD_HI_ADDR, KEY_FIRST)) begin
               consume = 1'b1; st_nxt = SQ_GOT1;
            end
            SQ_GOT1: if (hit(addr, din, CMD_LO_ADDR, KEY_SECOND)) begin
               consume = 1'b1; st_nxt = SQ_GOT2;
            end
            SQ_GOT2: if (hit(addr, din, CMD_HI_ADDR, KEY_LOCK)) begin
               consume = 1'b1; do_arm = 1'b1; st_nxt = SQ_OPEN;
            end else if (hit(addr, din, CMD_HI_ADDR, KEY_DIS_A)) begin
               consume = 1'b1; st_nxt = SQ_DIS3;
            end
            SQ_DIS3: if (hit(addr, din, CMD_HI_ADDR, KEY_FIRST)) begin
               consume = 1'b1; st_nxt = SQ_DIS4;
            end
            SQ_DIS4: if (hit(addr, din, CMD_LO_ADDR, KEY_SECOND)) begin
               consume = 1'b1; st_nxt = SQ_DIS5;
            end
            SQ_DIS5: if (hit(addr, din, CMD_HI_ADDR, KEY_DIS_B)) begin
               consume = 1'b1; do_disarm = 1'b1;
            end
            default: st_nxt = SQ_IDLE;
         endcase
      end
   end

   assign open_win = (st == SQ_OPEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SQ_IDLE;
         prot <= 1'b0;
      end else begin
         st <= st_nxt;
         if (do_arm)         prot <= 1'b1;
         else if (do_disarm) prot <= 1'b0;
      end
   end
endmodule

// File: rtl/eeg_wcycle.sv
module eeg_wcycle #(
   parameter int WC_CYCLES = 16,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] din,
   input  logic              rd_acc,
   output logic              busy,
   output logic              last_msb,
   output logic              tog
);
   localparam int CNT_W = $clog2(WC_CYCLES + 1);
   logic [CNT_W-1:0] cnt;

   assign busy = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         last_msb <= 1'b0;
         tog      <= 1'b0;
      end else begin
         if (start) begin
            cnt      <= CNT_W'(WC_CYCLES);
            last_msb <= din[DATA_W-1];
         end else if (busy) begin
            cnt <= cnt - 1'b1;
         end
         if (busy && rd_acc) tog <= ~tog;
      end
   end
endmodule

// File: rtl/eeg_array.sv
module eeg_array #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard #(
   parameter int ADDR_W    = 13,
   parameter int DATA_W    = 8,
   parameter int WC_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);
   generate
      if (ADDR_W < 13) begin : g_bad_addr
         $error("ADDR_W must be at least 13");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
      if (WC_CYCLES < 1) begin : g_bad_wc
         $error("WC_CYCLES must be at least 1");
      end
   endgenerate

   logic wr_acc, rd_acc, wr_go;
   logic prot, consume, open_win;
   logic busy, last_msb, tog;
   logic [DATA_W-1:0] mem_q, stat_w;

   assign wr_acc = !ce_n && !we_n;
   assign rd_acc = !ce_n && !oe_n && we_n;
   assign wr_go  = wr_acc && !consume && !busy && (!prot || open_win);

   eeg_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .rd_acc(rd_acc),
      .addr(addr), .din(din), .prot(prot), .consume(consume), .open_win(open_win));

   eeg_wcycle #(.WC_CYCLES(WC_CYCLES), .DATA_W(DATA_W)) u_wc (
      .clk(clk), .rst_n(rst_n), .start(wr_go), .din(din), .rd_acc(rd_acc),
      .busy(busy), .last_msb(last_msb), .tog(tog));

   eeg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk(clk), .we(wr_go), .addr(addr), .wdata(din), .rdata(mem_q));

   assign stat_w = {~last_msb, tog, {(DATA_W-2){1'b0}}};

   assign dq_oe  = rd_acc;
   assign dq_out = !rd_acc ? '0 : (busy ? stat_w : mem_q);
endmodule

// File: rtl/eeg_checker.sv
module eeg_checker #(
   parameter int WC_CYCLES = 16,
   parameter int DATA_W    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_acc,
   input logic              wr_go,
   input logic              busy,
   input logic              prot,
   input logic              dq_oe,
   input logic [DATA_W-1:0] dq_out
);
   localparam int RL_W = $clog2(WC_CYCLES + 1) + 1;
   logic [RL_W-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go |=> busy);
   p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run_len == RL_W'(WC_CYCLES));
   p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !wr_go);
   p_msb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && busy && $past(dq_oe && busy)) |-> dq_out[DATA_W-1] == $past(dq_out[DATA_W-1]));
   p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && busy && $past(dq_oe && busy)) |-> dq_out[DATA_W-2] != $past(dq_out[DATA_W-2]));
   p_prot_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prot) |-> $past(wr_acc));
endmodule

bind eeprom_guard eeg_checker #(.WC_CYCLES(WC_CYCLES), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_go(wr_go), .busy(busy),
   .prot(prot), .dq_oe(dq_oe), .dq_out(dq_out));

// File: tb/eeprom_guard_test.sv
module eeprom_guard_test;
   localparam int WC = 5;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [12:0] addr = '0;
   logic [7:0]  din = '0;
   logic [7:0]  dq_out;
   logic        dq_oe;
   int checks = 0, errors = 0;
   logic [7:0] mdl [0:8191];

   always #5 clk = ~clk;

   eeprom_guard #(.ADDR_W(13), .DATA_W(8), .WC_CYCLES(WC)) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [12:0] a, input logic [7:0] d);
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
      @(posedge clk); @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic rd(input logic [12:0] a, output logic [7:0] q, output logic oe);
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
      #1; q = dq_out; oe = dq_oe;
      @(posedge clk); @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd_chk(input string req, input logic [12:0] a, input logic [7:0] exp);
      logic [7:0] q; logic oe;
      rd(a, q, oe);
      check(req, {7'd0, oe}, 8'd1);
      check(req, q, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] q, prev;
      logic oe;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: undriven bus after reset
      #1; check("R1", {dq_out[6:0], dq_oe}, 8'd0);

      // R2: partial strobes are not reads
      ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; #1;
      check("R2", {7'd0, dq_oe}, 8'd0);
      check("R2", dq_out, 8'd0);
      ce_n = 1'b1; oe_n = 1'b0; #1;
      check("R2", {7'd0, dq_oe}, 8'd0);
      oe_n = 1'b1;
      @(negedge clk);

      // R1/R3: plain writes at the command addresses store while unprotected
      wr(13'h1555, 8'h3C); mdl[13'h1555] = 8'h3C; idle(WC + 1);
      wr(13'h0AAA, 8'h5A); mdl[13'h0AAA] = 8'h5A; idle(WC + 1);
      rd_chk("R1", 13'h1555, 8'h3C);
      rd_chk("R3", 13'h0AAA, 8'h5A);

      // R3: sweep of addresses and data
      for (int i = 0; i < 40; i++) begin
         logic [12:0] a; logic [7:0] d;
         a = 13'((i * 211 + 7) % 8192);
         if (a == 13'h1555 || a == 13'h0AAA) a = a + 13'd1;
         d = 8'((i * 37 + 11) % 256);
         wr(a, d); mdl[a] = d; idle(WC + 1);
         rd_chk("R3", a, d);
      end
      wr(13'h1FFF, 8'hFF); idle(WC + 1); rd_chk("R3", 13'h1FFF, 8'hFF);
      wr(13'h0000, 8'h01); idle(WC + 1); rd_chk("R3", 13'h0000, 8'h01);

      // R4/R5/R6: reads on every clock of the busy interval
      for (int p = 0; p < 2; p++) begin
         logic [7:0] d;
         d = (p == 0) ? 8'hC7 : 8'h35;
         wr(13'h0123, d);
         for (int j = 0; j <= WC; j++) begin
            rd(13'h0123, q, oe);
            if (j < WC) begin
               check("R5", {7'd0, q[7]}, {7'd0, ~d[7]});
               check("R6", {2'd0, q[5:0]}, 8'd0);
               if (j > 0) check("R6", {7'd0, q[6]}, {7'd0, ~prev[6]});
            end else begin
               check("R4", q, d);
            end
            prev = q;
         end
         rd_chk("R6", 13'h0123, d);
         rd_chk("R6", 13'h0123, d);
      end

      // R7: writes during busy are ignored
      wr(13'h0200, 8'h4E);
      wr(13'h0201, 8'h99);
      wr(13'h0200, 8'h11);
      idle(WC - 2);
      rd_chk("R7", 13'h0200, 8'h4E);
      rd_chk("R7", 13'h0201, mdl[13'h0201] === 8'hxx ? 8'hxx : mdl[13'h0201]);
      idle(WC);

      // R11/R12: unprotected broken sequence, mismatching write is plain
      wr(13'h1555, 8'hAA);
      rd_chk("R12", 13'h1555, 8'h3C);
      wr(13'h1555, 8'hAA);
      wr(13'h0100, 8'h12); idle(WC + 1);
      rd_chk("R11", 13'h0100, 8'h12);
      rd_chk("R12", 13'h1555, 8'h3C);

      // R8: arm, the following write is stored
      wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
      wr(13'h0300, 8'h6D); idle(WC + 1);
      rd_chk("R8", 13'h0300, 8'h6D);
      rd_chk("R12", 13'h1555, 8'h3C);
      rd_chk("R12", 13'h0AAA, 8'h5A);

      // R9: protected lone write changes nothing and starts no busy
      wr(13'h0300, 8'h00);
      rd_chk("R9", 13'h0300, 8'h6D);

      // R11: read aborts the arm sequence under protection
      wr(13'h1555, 8'hAA);
      rd_chk("R11", 13'h0300, 8'h6D);
      wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
      wr(13'h0300, 8'h77); idle(WC + 1);
      rd_chk("R11", 13'h0300, 8'h6D);
      // R11: a wrong address aborts
      wr(13'h1555, 8'hAA); wr(13'h0AAB, 8'h55); wr(13'h1555, 8'hA0);
      wr(13'h0300, 8'h78); idle(WC + 1);
      rd_chk("R11", 13'h0300, 8'h6D);
      rd_chk("R12", 13'h0AAB, mdl[13'h0AAB] === 8'hxx ? 8'hxx : mdl[13'h0AAB]);

      // R10: disarm, plain writes store again
      wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h80);
      wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h20);
      wr(13'h0300, 8'hB2); idle(WC + 1);
      rd_chk("R10", 13'h0300, 8'hB2);
      wr(13'h0301, 8'h2B); idle(WC + 1);
      rd_chk("R10", 13'h0301, 8'h2B);
      rd_chk("R12", 13'h1555, 8'h3C);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule